// File: doc/BRIEF.md
# Processor interrupt level resolver

This block decides, once per clock, whether the processor core should be interrupted and with which trap type. It folds the external level request lines, the software interrupt register and the two timer match flags into one mask of pending levels. It picks the highest pending level above the core's current priority level and presents it as a registered request line with a 9-bit trap index.

A second path accepts interrupt-vector events. A raise event claims the request line with the vector trap code and captures three data words. Level evaluation stays frozen until a lower event releases the vector. While the core is already inside a level trap, a new level trap that ranks below the one being handled is held back.

The vector data words are held register outputs that the core reads at its own pace. They carry no valid/ready handshake, so there is no back-pressure. Every other pin is plain control or status.

Top module: `irq_level_resolver`

## Requirements
- R1: While `rst_n` is low, `irq_req`, `trap_idx`, `vec_busy`, `wake` and all three vector data words are 0.
- R2: Pending levels are built as follows.
  - Level i (1..15) is pending when `ext_lvl[i]` or `soft_int[i]` is set.
  - `soft_int[0]` is the tick match flag and `soft_int[16]` is the system tick match flag. Either one makes level 14 pending.
  - `ext_lvl[0]` has no effect.
- R3: With `int_en` high and no vector pending, the highest pending level L with L > `pil` is selected. One clock later `trap_idx` = 0x040 | L and `irq_req` = 1.
- R4: When no pending level lies above `pil` and a request is active, one clock later `irq_req` = 0 and `trap_idx` = 0. For example, `pil` = 15 never selects a level.
- R5: When `int_en` is low and a request is active, one clock later `irq_req` = 0 and `trap_idx` = 0.
- R6: A new level request is suppressed, and the outputs keep their previous values, when all three of these hold:
  - `trap_lvl` is nonzero;
  - `cur_tt[8:4]` = 5'h04, meaning an external-interrupt trap is in progress;
  - `cur_tt` is greater than the new trap index.
  If any of the three does not hold, the request is raised as in R3.
- R7: A `vec_raise` while `vec_busy` is 0 has the following effect one clock later:
  - `vec_busy` = 1, `irq_req` = 1 and `trap_idx` = 0x060;
  - `vec_d0` = 0x7C0 | `vec_irq`, and `vec_d1` = `vec_d2` = 0;
  - `wake` pulses high for exactly one cycle.
- R8: While `vec_busy` is 1, level inputs (`ext_lvl`, `soft_int`, `pil`, `int_en`, `trap_lvl`, `cur_tt`) do not change `irq_req` or `trap_idx`. A further `vec_raise` leaves the data words and `wake` unchanged.
- R9: A `vec_lower` while `vec_busy` is 1 has the following effect one clock later:
  - `vec_busy` = 0 and `irq_req` = 0;
  - `trap_idx` is kept.
  Level evaluation resumes on the next clock. A `vec_lower` while `vec_busy` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_lvl | input | 16 | External level request lines, bit i = level i |
| soft_int | input | 17 | Software interrupt register; bit 0 tick flag, bit 16 system tick flag |
| pil | input | 4 | Current processor priority level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type of the trap in progress |
| vec_raise | input | 1 | Interrupt-vector raise event |
| vec_lower | input | 1 | Interrupt-vector lower event |
| vec_irq | input | 6 | Interrupt number carried by the vector |
| irq_req | output | 1 | Registered hardware interrupt request |
| trap_idx | output | 9 | Registered trap type of the request |
| vec_busy | output | 1 | Vector pending status |
| wake | output | 1 | One-cycle pulse that clears the core's halt state |
| vec_d0 | output | 64 | Vector data word 0 |
| vec_d1 | output | 64 | Vector data word 1 |
| vec_d2 | output | 64 | Vector data word 2 |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. This holds for the level request, the index, the vector capture and the one-cycle wake pulse, which falls again on the second edge. The bench drives inputs just after a rising edge, waits for the next rising edge, and samples a time step later, so each check looks at the first cycle in which the registered output may change. After a vector release, level evaluation resumes one further edge later, and the bench steps once more before checking it.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int TT_W = 9;
  localparam logic [TT_W-1:0] TT_EXT_BASE = 9'h040;
  localparam logic [TT_W-1:0] TT_VEC      = 9'h060;
  // class field of an external-interrupt trap type, bits 8:4
  localparam logic [4:0]      EXT_CLASS   = 5'h04;
endpackage

// File: rtl/irq_pend_mask.sv
module irq_pend_mask #(
  parameter int NLVL    = 16,
  parameter int TMR_LVL = 14
) (
  input  logic [NLVL-1:0] ext_lvl,
  input  logic [NLVL:0]   soft_int,
  output logic [NLVL-1:0] pend
);
  logic tmr_any;
  assign tmr_any = soft_int[0] | soft_int[NLVL];

  for (genvar i = 0; i < NLVL; i++) begin : g_bit
    if (i == 0) begin : g_zero
      // level 0 can never rank above a priority level
      assign pend[i] = 1'b0;
    end else if (i == TMR_LVL) begin : g_tmr
      assign pend[i] = ext_lvl[i] | soft_int[i] | tmr_any;
    end else begin : g_plain
      assign pend[i] = ext_lvl[i] | soft_int[i];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NLVL  = 16,
  parameter int LVL_W = $clog2(NLVL)
) (
  input  logic [NLVL-1:0]  pend,
  input  logic [LVL_W-1:0] pil,
  output logic             hit,
  output logic [LVL_W-1:0] lvl
);
  // ascending scan: the last match is the highest level above pil
  always_comb begin
    hit = 1'b0;
    lvl = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (pend[i] && (i > int'(pil))) begin
        hit = 1'b1;
        lvl = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_capture.sv
module irq_vec_capture #(
  parameter int IRQ_W  = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise,
  input  logic              lower,
  input  logic [IRQ_W-1:0]  irq,
  output logic              busy,
  output logic              accept,
  output logic              release_o,
  output logic              wake,
  output logic [DATA_W-1:0] d0,
  output logic [DATA_W-1:0] d1,
  output logic [DATA_W-1:0] d2
);
  localparam logic [DATA_W-1:0] D0_TAG = DATA_W'(11'h7C0);

  assign accept    = raise & ~busy;
  assign release_o = lower & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wake <= 1'b0;
      d0   <= '0;
      d1   <= '0;
      d2   <= '0;
    end else begin
      wake <= accept;
      if (accept) begin
        busy <= 1'b1;
        d0   <= D0_TAG | DATA_W'(irq);
        d1   <= '0;
        d2   <= '0;
      end else if (release_o) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_lvl_pkg::*;
#(
  parameter int NLVL    = 16,
  parameter int TMR_LVL = 14,
  parameter int TL_W    = 3,
  parameter int IRQ_W   = 6,
  parameter int DATA_W  = 64,
  localparam int LVL_W  = $clog2(NLVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   ext_lvl,
  input  logic [NLVL:0]     soft_int,
  input  logic [LVL_W-1:0]  pil,
  input  logic              int_en,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [TT_W-1:0]   cur_tt,
  input  logic              vec_raise,
  input  logic              vec_lower,
  input  logic [IRQ_W-1:0]  vec_irq,
  output logic              irq_req,
  output logic [TT_W-1:0]   trap_idx,
  output logic              vec_busy,
  output logic              wake,
  output logic [DATA_W-1:0] vec_d0,
  output logic [DATA_W-1:0] vec_d1,
  output logic [DATA_W-1:0] vec_d2
);
  logic [NLVL-1:0]  pend;
  logic             hit;
  logic [LVL_W-1:0] lvl;
  logic             accept, release_v;
  logic [TT_W-1:0]  new_idx;
  logic             nest_block;

  irq_pend_mask #(.NLVL(NLVL), .TMR_LVL(TMR_LVL)) u_mask (
    .ext_lvl (ext_lvl),
    .soft_int(soft_int),
    .pend    (pend)
  );

  irq_prio_pick #(.NLVL(NLVL), .LVL_W(LVL_W)) u_pick (
    .pend(pend),
    .pil (pil),
    .hit (hit),
    .lvl (lvl)
  );

  irq_vec_capture #(.IRQ_W(IRQ_W), .DATA_W(DATA_W)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise    (vec_raise),
    .lower    (vec_lower),
    .irq      (vec_irq),
    .busy     (vec_busy),
    .accept   (accept),
    .release_o(release_v),
    .wake     (wake),
    .d0       (vec_d0),
    .d1       (vec_d1),
    .d2       (vec_d2)
  );

  assign new_idx    = TT_EXT_BASE | TT_W'(lvl);
  assign nest_block = (trap_lvl != '0) && (cur_tt > new_idx) &&
                      (cur_tt[TT_W-1:4] == EXT_CLASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      trap_idx <= '0;
    end else if (accept) begin
      irq_req  <= 1'b1;
      trap_idx <= TT_VEC;
    end else if (release_v) begin
      irq_req  <= 1'b0;
    end else if (vec_busy) begin
      // vector owns the request; level path frozen
    end else if (!hit) begin
      if (irq_req) begin
        irq_req  <= 1'b0;
        trap_idx <= '0;
      end
    end else if (int_en) begin
      if (!nest_block && (trap_idx != new_idx)) begin
        irq_req  <= 1'b1;
        trap_idx <= new_idx;
      end
    end else if (irq_req) begin
      irq_req  <= 1'b0;
      trap_idx <= '0;
    end
  end
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk #(
  parameter int TT_W   = 9,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_raise,
  input logic              vec_lower,
  input logic              int_en,
  input logic              irq_req,
  input logic [TT_W-1:0]   trap_idx,
  input logic              vec_busy,
  input logic              wake,
  input logic [DATA_W-1:0] vec_d1,
  input logic [DATA_W-1:0] vec_d2
);
  a_r7_vec_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_raise && !vec_busy) |=> (irq_req && vec_busy && trap_idx == 9'h060 && wake));

  a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  a_r7_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_d1 == '0) && (vec_d2 == '0));

  a_r8_vec_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_busy && !vec_lower) |=> (vec_busy && $stable(irq_req) && $stable(trap_idx)));

  a_r9_vec_release: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_busy && vec_lower) |=> (!vec_busy && !irq_req && $stable(trap_idx)));

  a_r5_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && !vec_raise && !int_en) |=> !irq_req);

  a_r3_req_has_idx: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (trap_idx != '0));
endmodule

bind irq_level_resolver irq_level_resolver_chk #(.TT_W(9), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_irq_level_resolver.sv
module sim_irq_level_resolver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_lvl = '0;
  logic [16:0] soft_int = '0;
  logic [3:0]  pil = '0;
  logic        int_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  cur_tt = '0;
  logic        vec_raise = 1'b0;
  logic        vec_lower = 1'b0;
  logic [5:0]  vec_irq = '0;
  logic        irq_req;
  logic [8:0]  trap_idx;
  logic        vec_busy;
  logic        wake;
  logic [63:0] vec_d0, vec_d1, vec_d2;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_resolver u0 (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
    .pil(pil), .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
    .vec_raise(vec_raise), .vec_lower(vec_lower), .vec_irq(vec_irq),
    .irq_req(irq_req), .trap_idx(trap_idx), .vec_busy(vec_busy),
    .wake(wake), .vec_d0(vec_d0), .vec_d1(vec_d1), .vec_d2(vec_d2)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic chk_req(input string tag, input logic r, input logic [8:0] idx);
    chk({tag, " req"}, 64'(irq_req), 64'(r));
    chk({tag, " idx"}, 64'(trap_idx), 64'(idx));
  endtask

  task automatic t_reset();
    ext_lvl = 16'hFFFF; int_en = 1'b1; vec_raise = 1'b1;
    step(); step();
    chk_req("R1 reset", 1'b0, 9'h000);
    chk("R1 busy", 64'(vec_busy), 64'd0);
    chk("R1 wake", 64'(wake), 64'd0);
    chk("R1 d0", vec_d0, 64'd0);
    ext_lvl = '0; int_en = 1'b0; vec_raise = 1'b0;
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_mask();
    pil = 4'd0; int_en = 1'b1;
    ext_lvl = 16'h0001; step();
    chk_req("R2 ext bit0 ignored", 1'b0, 9'h000);
    soft_int = 17'h00001; step();
    chk_req("R2 tick flag -> 14", 1'b1, 9'h04E);
    soft_int = 17'h10000; ext_lvl = '0; step();
    chk_req("R2 stick flag -> 14", 1'b1, 9'h04E);
    soft_int = '0; ext_lvl = 16'h0020; step();
    chk_req("R2 ext level 5", 1'b1, 9'h045);
    soft_int = 17'h00200; step();
    chk_req("R2 soft level 9", 1'b1, 9'h049);
    soft_int = '0; ext_lvl = '0; step();
    chk_req("R4 nothing pending", 1'b0, 9'h000);
  endtask

  task automatic t_pick();
    ext_lvl = 16'hFFFF; pil = 4'd15; step();
    chk_req("R4 pil 15", 1'b0, 9'h000);
    pil = 4'd14; step();
    chk_req("R3 pil 14 picks 15", 1'b1, 9'h04F);
    ext_lvl = 16'h0018; pil = 4'd3; step();
    chk_req("R3 highest above pil", 1'b1, 9'h044);
    ext_lvl = 16'h0008; step();
    chk_req("R4 level equal pil drops", 1'b0, 9'h000);
    ext_lvl = '0; pil = '0;
  endtask

  task automatic t_enable();
    ext_lvl = 16'h0100; int_en = 1'b1; step();
    chk_req("R3 level 8", 1'b1, 9'h048);
    int_en = 1'b0; step();
    chk_req("R5 disabled drops", 1'b0, 9'h000);
    int_en = 1'b1; step();
    chk_req("R3 re-enabled", 1'b1, 9'h048);
    ext_lvl = '0; step();
  endtask

  task automatic t_nest();
    ext_lvl = 16'h0400; step();
    chk_req("R3 level 10", 1'b1, 9'h04A);
    trap_lvl = 3'd1; cur_tt = 9'h04D; ext_lvl = 16'h0C00; step();
    chk_req("R6 lower than nested suppressed", 1'b1, 9'h04A);
    ext_lvl = 16'h4000; step();
    chk_req("R6 higher than nested raised", 1'b1, 9'h04E);
    cur_tt = 9'h04F; ext_lvl = 16'h0800; step();
    chk_req("R6 suppressed keeps old", 1'b1, 9'h04E);
    cur_tt = 9'h068; step();
    chk_req("R6 non-external trap no block", 1'b1, 9'h04B);
    trap_lvl = 3'd0; cur_tt = 9'h04F; ext_lvl = 16'h0400; step();
    chk_req("R6 trap level 0 no block", 1'b1, 9'h04A);
    cur_tt = '0; ext_lvl = '0; step();
  endtask

  task automatic t_vec();
    ext_lvl = 16'h0040; int_en = 1'b1; step();
    chk_req("R3 level 6", 1'b1, 9'h046);
    vec_irq = 6'd5; vec_raise = 1'b1; step();
    vec_raise = 1'b0;
    chk_req("R7 vector claims", 1'b1, 9'h060);
    chk("R7 busy", 64'(vec_busy), 64'd1);
    chk("R7 wake", 64'(wake), 64'd1);
    chk("R7 d0", vec_d0, 64'h7C5);
    chk("R7 d1", vec_d1, 64'd0);
    chk("R7 d2", vec_d2, 64'd0);
    step();
    chk("R7 wake one cycle", 64'(wake), 64'd0);
    ext_lvl = 16'hFFFF; int_en = 1'b0; pil = 4'd2; step(); step();
    chk_req("R8 level path frozen", 1'b1, 9'h060);
    vec_irq = 6'd9; vec_raise = 1'b1; step();
    vec_raise = 1'b0;
    chk("R8 second raise data", vec_d0, 64'h7C5);
    chk("R8 second raise wake", 64'(wake), 64'd0);
    vec_lower = 1'b1; step();
    vec_lower = 1'b0;
    chk_req("R9 release", 1'b0, 9'h060);
    chk("R9 busy clear", 64'(vec_busy), 64'd0);
    step();
    chk_req("R9 disabled idle keeps idx", 1'b0, 9'h060);
    int_en = 1'b1; step();
    chk_req("R9 level resumes", 1'b1, 9'h04F);
    vec_lower = 1'b1; step();
    vec_lower = 1'b0;
    chk_req("R9 lower while idle no effect", 1'b1, 9'h04F);
    chk("R9 idle busy", 64'(vec_busy), 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    #1;
    t_reset();
    t_mask();
    t_pick();
    t_enable();
    t_nest();
    t_vec();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule